// File: doc/BRIEF.md
# Dual Converter Conversion Launch Controller

This block decides in which clock cycle each of a set of analog-to-digital conversion sequencers (two by default) is told to begin work. A start can come from two places. One is an external trigger pin, which passes through a synchronizer and is watched for a rising or a falling transition, chosen by a polarity input. The other is a software start strobe for each converter. The block sends each sequencer a one-cycle start pulse. It keeps a busy flag for each converter, and the sequencer clears that flag with a done pulse.

A request that arrives while its converter is busy is thrown away. It is not held for later. When dual launch is enabled, a request aimed at any converter starts every converter in the same cycle, but only if none of them is busy. Dual launch also needs matching configurations: the operating mode must be the same on every converter, and in continuous modes the channel count must be the same too. If either does not match, a configuration error flag goes high and no dual launch takes place.

Top module: `adc_launch_ctrl`

## Requirements
- R1: After reset, every start pulse and busy flag is low, and the configuration error flag is low while dual launch is disabled.
- R2: With rising polarity selected (edge_fall_i = 0), a low-to-high change on ext_trig_i raises start_o for each converter whose edge_en_i bit is 1. The pulse appears after the third rising clock edge at which the new pin level is present.
- R3: With falling polarity selected (edge_fall_i = 1), only high-to-low changes start a conversion, with the same three-edge latency. A change in the opposite direction starts nothing under either polarity.
- R4: A converter whose edge_en_i bit is 0 ignores the trigger pin. A one-cycle sw_start_i pulse for a converter raises its start_o in the following cycle.
- R5: Each accepted request gives a start pulse that lasts exactly one cycle. busy_o rises in the same cycle as start_o.
- R6: While busy_o is high and done_i is low for a converter, every request for it is discarded. A discarded request produces no start after the conversion completes.
- R7: A done_i pulse clears busy_o in the next cycle. A request in the same cycle as done_i is accepted: start_o pulses in the next cycle and busy_o stays high.
- R8: With dual_en_i = 1 and no configuration error, a request for any converter pulses start_o for all converters in the same cycle, but only if none of them is locked by busy. Otherwise the request is dropped.
- R9: cfg_err_o is combinational and is high when dual_en_i = 1 and either of these holds: the 2-bit mode fields differ, or the modes match, mode bit 0 is 1 (continuous), and the 3-bit channel counts differ.
- R10: While dual_en_i and cfg_err_o are both high, no start pulse is produced for any converter.
- R11: Outside dual launch, edge and software starts work the same way for every value of the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| edge_fall_i | input | 1 | Trigger polarity: 0 = rising, 1 = falling |
| edge_en_i | input | NUM_CONV | Per-converter enable for the trigger pin |
| sw_start_i | input | NUM_CONV | Per-converter software start strobe |
| dual_en_i | input | 1 | Dual launch enable |
| mode_i | input | NUM_CONV*MODE_W | Operating mode of each converter (converter 0 in the low bits) |
| chan_cnt_i | input | NUM_CONV*CNT_W | Channel count of each converter |
| done_i | input | NUM_CONV | Conversion-complete pulse from each sequencer |
| start_o | output | NUM_CONV | One-cycle start pulse for each sequencer |
| busy_o | output | NUM_CONV | Conversion in progress, per converter |
| cfg_err_o | output | 1 | Dual launch configuration mismatch |

## Verification
A pin transition is due at start_o three rising edges after it is first sampled: two synchronizer stages and the output register. Software strobes and requests that arrive with done_i are due one edge after they are sampled, and busy_o changes at that same edge. cfg_err_o follows the configuration inputs within the same cycle. The bench drives inputs on the falling clock edge and steps a reference model once per rising edge. It compares every output at the next falling edge, so each result is compared in exactly the cycle it is due, and a pulse that is early or late by one cycle is reported.

// File: rtl/adc_launch_pkg.sv
package adc_launch_pkg;

   // Trigger polarity selection, taken from a single select bit.
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_pol_e;

   // Launch policy applied by the arbiter in a given cycle.
   typedef enum logic [1:0] {
      POLICY_SPLIT  = 2'b00,
      POLICY_GANGED = 2'b01,
      POLICY_BLOCK  = 2'b10
   } launch_policy_e;

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
   import adc_launch_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic fall_sel_i,
   output logic edge_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("adc_trig_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   level;
   edge_pol_e              pol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], trig_i};
      end
   end

   assign level = sync_q[SYNC_STAGES-1];

   // Holds the previous synchronized level for transition detection
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= 1'b0;
      end else begin
         last_q <= level;
      end
   end

   assign pol = edge_pol_e'(fall_sel_i);

   always_comb begin
      unique case (pol)
         EDGE_RISE: edge_o = level & ~last_q;
         EDGE_FALL: edge_o = ~level & last_q;
         default:   edge_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/adc_cfg_match.sv
module adc_cfg_match #(
   parameter int unsigned NUM_CONV = 2,
   parameter int unsigned MODE_W   = 2,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned CONT_BIT = 0
) (
   input  logic                       dual_en_i,
   input  logic [NUM_CONV*MODE_W-1:0] mode_i,
   input  logic [NUM_CONV*CNT_W-1:0]  cnt_i,
   output logic                       err_o
);

   generate
      if (CONT_BIT >= MODE_W) begin : g_bad_bit
         $error("adc_cfg_match: CONT_BIT outside the mode field");
      end
   endgenerate

   logic [NUM_CONV-1:0] mode_diff;
   logic [NUM_CONV-1:0] cnt_diff;
   logic [MODE_W-1:0]   ref_mode;
   logic [CNT_W-1:0]    ref_cnt;
   logic                continuous;

   assign ref_mode   = mode_i[MODE_W-1:0];
   assign ref_cnt    = cnt_i[CNT_W-1:0];
   assign continuous = ref_mode[CONT_BIT];

   // Compare every converter against converter 0
   genvar c;
   generate
      for (c = 0; c < NUM_CONV; c++) begin : g_cmp
         if (c == 0) begin : g_ref
            assign mode_diff[c] = 1'b0;
            assign cnt_diff[c]  = 1'b0;
         end else begin : g_other
            assign mode_diff[c] = (mode_i[c*MODE_W +: MODE_W] != ref_mode);
            assign cnt_diff[c]  = (cnt_i[c*CNT_W +: CNT_W] != ref_cnt);
         end
      end
   endgenerate

   assign err_o = dual_en_i & ((|mode_diff) | (continuous & (|cnt_diff)));

endmodule

// File: rtl/adc_launch_arb.sv
module adc_launch_arb
   import adc_launch_pkg::*;
#(
   parameter int unsigned NUM_CONV = 2
) (
   input  logic                dual_en_i,
   input  logic                cfg_err_i,
   input  logic [NUM_CONV-1:0] req_i,
   input  logic [NUM_CONV-1:0] free_i,
   output logic [NUM_CONV-1:0] launch_o
);

   launch_policy_e policy;
   logic           any_req;
   logic           all_free;

   assign any_req  = |req_i;
   assign all_free = &free_i;

   always_comb begin
      if (!dual_en_i)      policy = POLICY_SPLIT;
      else if (cfg_err_i)  policy = POLICY_BLOCK;
      else                 policy = POLICY_GANGED;
   end

   always_comb begin
      unique case (policy)
         POLICY_SPLIT:  launch_o = req_i & free_i;
         POLICY_GANGED: launch_o = (any_req && all_free) ? '1 : '0;
         default:       launch_o = '0;
      endcase
   end

endmodule

// File: rtl/adc_conv_lock.sv
module adc_conv_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic done_i,
   output logic free_o,
   output logic start_o,
   output logic busy_o
);

   logic start_q;
   logic busy_q;

   // A done in this cycle releases the lock for a request in the same cycle
   assign free_o = ~busy_q | done_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         start_q <= launch_i;
         if (launch_i)    busy_q <= 1'b1;
         else if (done_i) busy_q <= 1'b0;
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;

endmodule

// File: rtl/adc_launch_ctrl.sv
module adc_launch_ctrl #(
   parameter int unsigned NUM_CONV    = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned CNT_W       = 3,
   parameter int unsigned CONT_BIT    = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ext_trig_i,
   input  logic                       edge_fall_i,
   input  logic [NUM_CONV-1:0]        edge_en_i,
   input  logic [NUM_CONV-1:0]        sw_start_i,
   input  logic                       dual_en_i,
   input  logic [NUM_CONV*MODE_W-1:0] mode_i,
   input  logic [NUM_CONV*CNT_W-1:0]  chan_cnt_i,
   input  logic [NUM_CONV-1:0]        done_i,
   output logic [NUM_CONV-1:0]        start_o,
   output logic [NUM_CONV-1:0]        busy_o,
   output logic                       cfg_err_o
);

   generate
      if (NUM_CONV < 2) begin : g_bad_count
         $error("adc_launch_ctrl: NUM_CONV must be at least 2");
      end
   endgenerate

   logic                pin_edge;
   logic                cfg_err;
   logic [NUM_CONV-1:0] req;
   logic [NUM_CONV-1:0] free;
   logic [NUM_CONV-1:0] launch;

   adc_trig_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) edge_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (ext_trig_i),
      .fall_sel_i (edge_fall_i),
      .edge_o     (pin_edge)
   );

   adc_cfg_match #(
      .NUM_CONV (NUM_CONV),
      .MODE_W   (MODE_W),
      .CNT_W    (CNT_W),
      .CONT_BIT (CONT_BIT)
   ) cfg_i (
      .dual_en_i (dual_en_i),
      .mode_i    (mode_i),
      .cnt_i     (chan_cnt_i),
      .err_o     (cfg_err)
   );

   assign req = ({NUM_CONV{pin_edge}} & edge_en_i) | sw_start_i;

   adc_launch_arb #(
      .NUM_CONV (NUM_CONV)
   ) arb_i (
      .dual_en_i (dual_en_i),
      .cfg_err_i (cfg_err),
      .req_i     (req),
      .free_i    (free),
      .launch_o  (launch)
   );

   genvar c;
   generate
      for (c = 0; c < NUM_CONV; c++) begin : g_conv
         adc_conv_lock lock_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .launch_i (launch[c]),
            .done_i   (done_i[c]),
            .free_o   (free[c]),
            .start_o  (start_o[c]),
            .busy_o   (busy_o[c])
         );
      end
   endgenerate

   assign cfg_err_o = cfg_err;

endmodule

// File: rtl/adc_launch_ctrl_chk.sv
module adc_launch_ctrl_chk #(
   parameter int unsigned NUM_CONV = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dual_en_i,
   input logic [NUM_CONV-1:0] done_i,
   input logic [NUM_CONV-1:0] start_o,
   input logic [NUM_CONV-1:0] busy_o,
   input logic                cfg_err_o
);

   genvar c;
   generate
      for (c = 0; c < NUM_CONV; c++) begin : g_per_conv
         // R5
         busy_rise_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_o[c]) |-> start_o[c]);

         // R6
         locked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o[c] && !done_i[c]) |=> !start_o[c]);

         // R6
         busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o[c] && !done_i[c]) |=> busy_o[c]);

         // R7
         done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o[c] && done_i[c]) |=> (busy_o[c] == start_o[c]));
      end
   endgenerate

   // R8
   ganged_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_en_i && !cfg_err_o) |=> (start_o == '0 || start_o == '1));

   // R10
   cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dual_en_i && cfg_err_o) |=> (start_o == '0));

   // R9
   cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_en_i |-> !cfg_err_o);

endmodule

bind adc_launch_ctrl adc_launch_ctrl_chk #(
   .NUM_CONV (NUM_CONV)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .dual_en_i (dual_en_i),
   .done_i    (done_i),
   .start_o   (start_o),
   .busy_o    (busy_o),
   .cfg_err_o (cfg_err_o)
);

// File: tb/adc_launch_ctrl_tb_top.sv
module adc_launch_ctrl_tb_top;

   localparam int NC = 2;
   localparam int MW = 2;
   localparam int CW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   logic             rst_n;
   logic             ext_trig_i;
   logic             edge_fall_i;
   logic [NC-1:0]    edge_en_i;
   logic [NC-1:0]    sw_start_i;
   logic             dual_en_i;
   logic [NC*MW-1:0] mode_i;
   logic [NC*CW-1:0] chan_cnt_i;
   logic [NC-1:0]    done_i;
   logic [NC-1:0]    start_o;
   logic [NC-1:0]    busy_o;
   logic             cfg_err_o;

   adc_launch_ctrl #(
      .NUM_CONV (NC), .SYNC_STAGES (2), .MODE_W (MW), .CNT_W (CW), .CONT_BIT (0)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .ext_trig_i (ext_trig_i), .edge_fall_i (edge_fall_i),
      .edge_en_i (edge_en_i), .sw_start_i (sw_start_i), .dual_en_i (dual_en_i),
      .mode_i (mode_i), .chan_cnt_i (chan_cnt_i), .done_i (done_i),
      .start_o (start_o), .busy_o (busy_o), .cfg_err_o (cfg_err_o)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // Reference model state, as seen after the most recent rising edge
   logic          m_s0, m_s1, m_prev;
   logic [NC-1:0] m_busy, m_start;

   function automatic logic exp_cfg(logic dual, logic [NC*MW-1:0] md, logic [NC*CW-1:0] cn);
      logic mism;
      mism = (md[MW-1:0] != md[2*MW-1:MW]);
      if (!mism && md[0]) mism = (cn[CW-1:0] != cn[2*CW-1:CW]);
      return dual & mism;
   endfunction

   task automatic check(string tag, logic [2*NC:0] act, logic [2*NC:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s {cfg_err,busy,start} actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_busy = '0; m_start = '0;
   endtask

   // One clock: advance the model with the present inputs, then compare
   task automatic cyc(string tag);
      logic          e, err;
      logic [NC-1:0] req, free, launch;
      e    = edge_fall_i ? (~m_s1 & m_prev) : (m_s1 & ~m_prev);
      req  = ({NC{e}} & edge_en_i) | sw_start_i;
      free = ~m_busy | done_i;
      err  = exp_cfg(dual_en_i, mode_i, chan_cnt_i);
      if (dual_en_i) launch = (|req && !err && &free) ? '1 : '0;
      else           launch = req & free;
      m_busy  = launch | (m_busy & ~done_i);
      m_start = launch;
      m_prev  = m_s1; m_s1 = m_s0; m_s0 = ext_trig_i;
      @(posedge clk);
      @(negedge clk);
      check(tag, {cfg_err_o, busy_o, start_o},
            {exp_cfg(dual_en_i, mode_i, chan_cnt_i), m_busy, m_start});
   endtask

   task automatic run(string tag, int n);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   task automatic sw_pulse(string tag, logic [NC-1:0] v);
      sw_start_i = v; cyc(tag); sw_start_i = '0;
   endtask

   task automatic finish_conv(string tag, logic [NC-1:0] v);
      done_i = v; cyc(tag); done_i = '0;
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; ext_trig_i = 0; edge_fall_i = 0; edge_en_i = '0; sw_start_i = '0;
      dual_en_i = 0; mode_i = '0; chan_cnt_i = '0; done_i = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      check("R1", {cfg_err_o, busy_o, start_o}, '0);

      // R2: rising edge, converter 0 only, three-edge latency
      edge_en_i = 2'b01; ext_trig_i = 1;
      run("R2", 2);
      check("R2 early", {1'b0, start_o}, '0);
      cyc("R2");
      check("R2 due", {1'b0, start_o}, {1'b0, 2'b01});
      run("R5", 1);
      check("R5 one cycle", {1'b0, start_o}, '0);
      finish_conv("R7", 2'b01);

      // R3: falling change ignored under rising polarity, then falling polarity
      ext_trig_i = 0; run("R3", 4);
      edge_fall_i = 1; ext_trig_i = 1; run("R3", 4);
      ext_trig_i = 0; run("R3", 2);
      cyc("R3");
      check("R3 due", {1'b0, start_o}, {1'b0, 2'b01});
      run("R3", 1);
      finish_conv("R7", 2'b01);
      edge_fall_i = 0; run("R3", 3);

      // R4: trigger disabled, software start
      edge_en_i = 2'b00; ext_trig_i = 1; run("R4", 4); ext_trig_i = 0; run("R4", 4);
      sw_pulse("R4", 2'b10);
      check("R4 sw", {1'b0, start_o}, {1'b0, 2'b10});
      finish_conv("R7", 2'b10);

      // R6: edge while busy is dropped and not replayed
      edge_en_i = 2'b01;
      sw_pulse("R6", 2'b01);
      ext_trig_i = 1; run("R6", 6);
      finish_conv("R6", 2'b01);
      run("R6", 4);
      check("R6 no replay", {1'b0, busy_o, start_o}, '0);
      ext_trig_i = 0; run("R6", 3);

      // R7: request in the done cycle is accepted
      sw_pulse("R7", 2'b01);
      sw_start_i = 2'b01; done_i = 2'b01; cyc("R7");
      sw_start_i = '0; done_i = '0;
      check("R7 accept", {1'b0, busy_o, start_o}, {1'b0, 2'b01, 2'b01});
      finish_conv("R7", 2'b01);

      // R8: dual launch from converter 1 trigger only
      dual_en_i = 1; mode_i = 4'b1010; chan_cnt_i = 6'o33; edge_en_i = 2'b10;
      ext_trig_i = 1; run("R8", 3);
      check("R8 both", {1'b0, start_o}, {1'b0, 2'b11});
      ext_trig_i = 0; run("R8", 3);
      finish_conv("R8", 2'b10);
      sw_pulse("R8", 2'b10);
      check("R8 dropped", {1'b0, start_o}, '0);
      finish_conv("R8", 2'b01);
      sw_pulse("R8", 2'b01);
      finish_conv("R8", 2'b11);

      // R9 and R10: configuration mismatches
      mode_i = 4'b0110; run("R9", 1);
      check("R9 mode", {cfg_err_o, 4'b0}, {1'b1, 4'b0});
      sw_pulse("R10", 2'b11);
      check("R10 block", {1'b0, start_o}, '0);
      mode_i = 4'b0101; chan_cnt_i = 6'o12; run("R9", 1);
      check("R9 count", {cfg_err_o, 4'b0}, {1'b1, 4'b0});
      sw_pulse("R10", 2'b01);
      mode_i = 4'b1010; run("R9", 2);
      check("R9 no count", {cfg_err_o, 4'b0}, '0);
      dual_en_i = 0;

      // R11: every mode value, edge start outside dual launch
      edge_en_i = 2'b11;
      for (int m = 0; m < 4; m++) begin
         mode_i = {m[1:0], m[1:0]};
         ext_trig_i = ~ext_trig_i; edge_fall_i = ~ext_trig_i;
         run("R11", 3);
         check("R11 mode", {1'b0, start_o}, {1'b0, 2'b11});
         finish_conv("R11", 2'b11);
         run("R11", 2);
      end

      // Random phase, checked against the model each cycle
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(3) == 0) ext_trig_i = ~ext_trig_i;
         if ($urandom_range(63) == 0) edge_fall_i = ~edge_fall_i;
         if ($urandom_range(15) == 0) edge_en_i = NC'($urandom);
         sw_start_i = ($urandom_range(7) == 0) ? NC'($urandom) : '0;
         done_i = NC'($urandom) & (($urandom_range(3) == 0) ? m_busy : '0);
         if ($urandom_range(31) == 0) dual_en_i = ~dual_en_i;
         if ($urandom_range(31) == 0) begin
            mode_i = NC*MW'($urandom);
            if ($urandom_range(1) == 0) mode_i[2*MW-1:MW] = mode_i[MW-1:0];
            chan_cnt_i = NC*CW'($urandom);
            if ($urandom_range(1) == 0) chan_cnt_i[2*CW-1:CW] = chan_cnt_i[CW-1:0];
         end
         cyc("R5 R8 random");
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule